// File: doc/BRIEF.md
# Watchdog Key-Sequence Reset Controller

This block is a watchdog with a 64-bit up-counter. It cannot time out or reset the system until software has unlocked it with a two-key handshake. A small register window lets software set up the counter, the period and a global configuration word. Writes to a control word carry an enable flag and a 16-bit key, and these writes move the block through its states: disabled, enabled, pre-active and armed.

When the block is armed, the counter advances by one on every clock. A system reset pulse of fixed length is raised in two cases: the counter reaches the programmed period, or software writes a key that breaks the sequence. Software services the watchdog by writing the same two keys again. This returns the counter to zero. Arming locks the configuration, the counter and the period against software writes. Only the block's own reset input brings it back to the disabled state.

Top module: `wdt_key_reset`

## Requirements
- R1: After `rst_n` is held low, the control word reads 0, the counter, period and configuration word read 0, and `sys_rst_o` is low.
- R2: Control-word writes take effect only while the configuration word (offset 0x24) holds 2 in bits 3:2 (watchdog mode) and 1 in both bits 1 and 0 (both halves released). Otherwise they are ignored.
- R3: The control word is at offset 0x28. The enable flag is bit 14 and the key is bits 31:16. An enable-only write moves the block from disabled to enabled. Key 0xA5C6 with enable moves it to pre-active. Key 0xDA7E with enable, written while pre-active, arms it. Bit 14 reads 1 in every state except disabled.
- R4: Before the block is armed, a write whose key is not the next expected key changes nothing and raises no reset. A write with bit 14 clear returns the block to disabled.
- R5: While armed, a control write whose key is neither expected key raises `sys_rst_o` on the next cycle. This includes the value 0x00004000.
- R6: While armed, key 0xA5C6 followed by key 0xDA7E clears the counter to zero with no reset. Any other key written after 0xA5C6 raises the reset.
- R7: While armed, the counter increases by one each clock. On the cycle after the counter equals the period, `sys_rst_o` rises.
- R8: `sys_rst_o` stays high for exactly 16 cycles. It then stays low until `rst_n`, and later writes neither restart nor extend it.
- R9: Once armed, writes to the counter, the period and the configuration word are ignored, and bit 14 of the control word stays 1.
- R10: The counter is at 0x10 (low word) and 0x14 (high word). The period is at 0x18 (low word) and 0x1C (high word). Both can be written while the block is not armed, and the counter carries from the low word into the high word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Byte offset of the read |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The hardest cases to reach from the ports are a timeout that depends on a carry out of the low counter word, and a service sequence that completes just before the period expires. The stimulus preloads the counter to a few counts below the 32-bit boundary and uses a period with a non-zero high word, so the carry happens within a few dozen cycles. The service case lets a short period partly run out, services the counter, and then measures the complete timeout window again from the clearing edge.

// File: rtl/wdt_pkg.sv
`timescale 1ns/100ps
// Shared definitions for the key-sequence watchdog: state encoding,
// unlock keys, control-word field positions and register offsets.
package wdt_pkg;
    typedef enum logic [2:0] {
        WD_OFF,
        WD_EN,
        WD_PRE,
        WD_ARMED,
        WD_SVC,
        WD_BIT
    } wd_state_e;

    localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
    localparam logic [15:0] KEY_SECOND = 16'hDA7E;
    localparam int          EN_BIT     = 14;
    localparam int          KEY_LSB    = 16;
    localparam int          KEY_W      = 16;

    localparam logic [5:0]  A_CNT = 6'h10;
    localparam logic [5:0]  A_PRD = 6'h18;
    localparam logic [5:0]  A_GCR = 6'h24;
    localparam logic [5:0]  A_CTL = 6'h28;

    // watchdog mode (2) in bits 3:2, both release bits set
    localparam logic [3:0]  GCR_WDOG = 4'b1011;
endpackage

// File: rtl/wdt_key_fsm.sv
`timescale 1ns/100ps
// Key-sequence state machine. Tracks unlock progress, arming and
// servicing, and decides when the watchdog bites.
// Assumes: ctl_wr is a single-cycle control-word write strobe, and
// cfg_ok is stable while armed (the top locks the configuration).
module wdt_key_fsm
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ok,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic [KEY_W-1:0] ctl_key,
    input  logic             tmo,
    output wd_state_e        state,
    output logic             armed,
    output logic             bite,
    output logic             svc_clr
);
    wd_state_e nxt;

    assign armed = (state == WD_ARMED) || (state == WD_SVC);

    // Next state, bite decision and service clear
    always_comb begin
        nxt     = state;
        bite    = 1'b0;
        svc_clr = 1'b0;
        if (armed && tmo) begin
            bite = 1'b1;
            nxt  = WD_BIT;
        end else if (ctl_wr) begin
            unique case (state)
                WD_OFF: if (cfg_ok && ctl_en) nxt = WD_EN;
                WD_EN: begin
                    if (cfg_ok) begin
                        if (!ctl_en)                    nxt = WD_OFF;
                        else if (ctl_key == KEY_FIRST)  nxt = WD_PRE;
                    end
                end
                WD_PRE: begin
                    if (cfg_ok) begin
                        if (!ctl_en)                    nxt = WD_OFF;
                        else if (ctl_key == KEY_SECOND) nxt = WD_ARMED;
                    end
                end
                WD_ARMED: begin
                    if (ctl_key == KEY_FIRST) nxt = WD_SVC;
                    else begin
                        bite = 1'b1;
                        nxt  = WD_BIT;
                    end
                end
                WD_SVC: begin
                    if (ctl_key == KEY_SECOND) begin
                        svc_clr = 1'b1;
                        nxt     = WD_ARMED;
                    end else begin
                        bite = 1'b1;
                        nxt  = WD_BIT;
                    end
                end
                default: nxt = state;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WD_OFF;
        else        state <= nxt;
    end
endmodule

// File: rtl/wdt_count64.sv
`timescale 1ns/100ps
// Wide up-counter and period register, each written as NH words of
// DW bits. Raises tmo while the counter equals the period.
// Assumes: run is only asserted while lock is asserted.
module wdt_count64 #(
    parameter int DW = 32,
    parameter int NH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NH-1:0]     wr_cnt,
    input  logic [NH-1:0]     wr_prd,
    input  logic [DW-1:0]     wr_data,
    input  logic              lock,
    input  logic              run,
    input  logic              clr,
    output logic [DW*NH-1:0]  cnt,
    output logic [DW*NH-1:0]  prd,
    output logic              tmo
);
    localparam int CNT_W = DW * NH;

    // Counter: clear on service, advance while armed, else software load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end else if (!lock) begin
            for (int h = 0; h < NH; h++)
                if (wr_cnt[h]) cnt[h*DW +: DW] <= wr_data;
        end
    end

    // Period: software load while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd <= '0;
        end else if (!lock) begin
            for (int h = 0; h < NH; h++)
                if (wr_prd[h]) prd[h*DW +: DW] <= wr_data;
        end
    end

    assign tmo = (cnt == prd);
endmodule

// File: rtl/wdt_rst_pulse.sv
`timescale 1ns/100ps
// Stretches a one-cycle bite into a reset pulse of PULSE_LEN cycles.
// Assumes: bite occurs at most once between resets.
module wdt_rst_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bite,
    output logic rst_out
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left;

    // Remaining pulse length: load on bite, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                   left <= '0;
        else if (bite && left == '0)  left <= PW'(PULSE_LEN);
        else if (left != '0)          left <= left - PW'(1);
    end

    assign rst_out = (left != '0);
endmodule

// File: rtl/wdt_key_reset.sv
`timescale 1ns/100ps
// Top of the key-sequence watchdog: register decode, configuration
// word, read mux, and the FSM, counter and pulse stages.
// Assumes: DW is 32, so the key sits in bits 31:16 of the control word.
module wdt_key_reset
    import wdt_pkg::*;
#(
    parameter int DW        = 32,
    parameter int CNT_W     = 64,
    parameter int PULSE_LEN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [5:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [5:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          sys_rst_o
);
    localparam int NH = CNT_W / DW;

    wd_state_e         st;
    logic              armed, bite, svc_clr, tmo, locked, ctl_wr;
    logic [3:0]        gcr;
    logic [NH-1:0]     wr_cnt, wr_prd;
    logic [CNT_W-1:0]  cnt, prd;

    assign ctl_wr = wr_en && (wr_addr == A_CTL);
    assign locked = armed || (st == WD_BIT);

    // Per-word write strobes for counter and period
    for (genvar h = 0; h < NH; h++) begin : g_strb
        assign wr_cnt[h] = wr_en && (wr_addr == A_CNT + 6'(4 * h));
        assign wr_prd[h] = wr_en && (wr_addr == A_PRD + 6'(4 * h));
    end

    // Configuration word, frozen once armed
    always_ff @(posedge clk) begin
        if (!rst_n)                                     gcr <= '0;
        else if (wr_en && wr_addr == A_GCR && !locked)  gcr <= wr_data[3:0];
    end

    wdt_key_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_ok  (gcr == GCR_WDOG),
        .ctl_wr  (ctl_wr),
        .ctl_en  (wr_data[EN_BIT]),
        .ctl_key (wr_data[KEY_LSB +: KEY_W]),
        .tmo     (tmo),
        .state   (st),
        .armed   (armed),
        .bite    (bite),
        .svc_clr (svc_clr)
    );

    wdt_count64 #(.DW(DW), .NH(NH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cnt  (wr_cnt),
        .wr_prd  (wr_prd),
        .wr_data (wr_data),
        .lock    (locked),
        .run     (armed),
        .clr     (svc_clr),
        .cnt     (cnt),
        .prd     (prd),
        .tmo     (tmo)
    );

    wdt_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
        .clk     (clk),
        .rst_n   (rst_n),
        .bite    (bite),
        .rst_out (sys_rst_o)
    );

    // Read mux
    always_comb begin
        rd_data = '0;
        for (int h = 0; h < NH; h++) begin
            if (rd_addr == A_CNT + 6'(4 * h)) rd_data = cnt[h*DW +: DW];
            if (rd_addr == A_PRD + 6'(4 * h)) rd_data = prd[h*DW +: DW];
        end
        if (rd_addr == A_GCR) rd_data[3:0]   = gcr;
        if (rd_addr == A_CTL) rd_data[EN_BIT] = (st != WD_OFF);
    end
endmodule

// File: rtl/wdt_key_reset_chk.sv
`timescale 1ns/100ps
// Property checker for the key-sequence watchdog, bound to the top.
module wdt_key_reset_chk
    import wdt_pkg::*;
#(
    parameter int DW        = 32,
    parameter int CNT_W     = 64,
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_state_e        st,
    input  logic             sys_rst_o,
    input  logic             wr_en,
    input  logic [5:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [CNT_W-1:0] cnt,
    input  logic [3:0]       gcr,
    input  logic             tmo
);
    localparam int HW = $clog2(PULSE_LEN + 2);
    logic [HW-1:0] hcnt;

    // Length of the current reset pulse so far
    always_ff @(posedge clk) begin
        if (!rst_n)         hcnt <= '0;
        else if (sys_rst_o) hcnt <= hcnt + HW'(1);
        else                hcnt <= '0;
    end

    a_r8_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> hcnt < HW'(PULSE_LEN));

    a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> hcnt == HW'(PULSE_LEN));

    a_r3_arm_via_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_ARMED && $past(st) != WD_ARMED && $past(st) != WD_SVC)
        |-> $past(st) == WD_PRE);

    a_r5_rst_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> ($past(st) == WD_ARMED || $past(st) == WD_SVC));

    a_r9_gcr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_ARMED || st == WD_SVC || st == WD_BIT) |=> $stable(gcr));

    a_r6_service_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_SVC && wr_en && wr_addr == A_CTL &&
         wr_data[KEY_LSB +: KEY_W] == KEY_SECOND && !tmo) |=> cnt == '0);

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == WD_OFF || st == WD_EN || st == WD_PRE) && !wr_en) |=> $stable(cnt));
endmodule

bind wdt_key_reset wdt_key_reset_chk #(
    .DW(DW), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .sys_rst_o (sys_rst_o),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cnt       (cnt),
    .gcr       (gcr),
    .tmo       (tmo)
);

// File: tb/sim_wdt_key_reset.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver queues expected observations and a
// monitor compares them against the ports once per cycle.
module sim_wdt_key_reset;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sys_rst_o;

    localparam logic [31:0] EN   = 32'h0000_4000;
    localparam logic [31:0] K0   = 32'hA5C6_4000;
    localparam logic [31:0] K1   = 32'hDA7E_4000;
    localparam logic [5:0]  CLO = 6'h10, CHI = 6'h14, PLO = 6'h18, PHI = 6'h1C;
    localparam logic [5:0]  GCR = 6'h24, CTL = 6'h28;

    typedef struct {
        string       req;
        bit          is_rst;
        logic [5:0]  addr;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdt_key_reset u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sys_rst_o(sys_rst_o)
    );

    task automatic exp_reg(string req, logic [5:0] a, logic [31:0] e);
        item_t it;
        it.req = req; it.is_rst = 1'b0; it.addr = a; it.exp = e;
        q.push_back(it);
    endtask

    task automatic exp_rst(string req, logic e);
        item_t it;
        it.req = req; it.is_rst = 1'b1; it.addr = '0; it.exp = {31'b0, e};
        q.push_back(it);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        cyc(2); rst_n = 1'b1;
    endtask

    task automatic arm(logic [31:0] plo, logic [31:0] phi,
                       logic [31:0] clo, logic [31:0] chi);
        wr(GCR, 32'hB);
        wr(CLO, clo); wr(CHI, chi);
        wr(PLO, plo); wr(PHI, phi);
        wr(CTL, EN); wr(CTL, K0); wr(CTL, K1);
    endtask

    // Monitor: pops queued expectations after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                rd_addr = it.addr;
                #0.1;
                got = it.is_rst ? {31'b0, sys_rst_o} : rd_data;
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
                end
            end
        end
    end

    // Watchdog for a hung run
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver
    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        exp_rst("R1 rst", 1'b0);
        exp_reg("R1 ctl", CTL, 32'h0);
        exp_reg("R1 cnt", CLO, 32'h0);
        exp_reg("R1 prd", PLO, 32'h0);
        exp_reg("R1 gcr", GCR, 32'h0);

        // R2 enable ignored without watchdog configuration
        wr(GCR, 32'h7);
        wr(CTL, EN);
        exp_reg("R2 ctl unconfigured", CTL, 32'h0);
        wr(GCR, 32'hB);
        exp_reg("R2 gcr", GCR, 32'hB);
        // R3 enable
        wr(CTL, EN);
        exp_reg("R3 enabled", CTL, EN);
        // R4 wrong / out-of-order keys ignored
        wr(CTL, 32'h1234_4000);
        wr(CTL, K1);
        exp_rst("R4 no rst", 1'b0);
        wr(CTL, K0);
        wr(CTL, 32'h0BAD_4000);
        exp_rst("R4 no rst pre", 1'b0);
        exp_reg("R4 still enabled", CTL, EN);
        wr(CTL, 32'h0);
        exp_reg("R4 disabled", CTL, 32'h0);

        // R7 timeout and R8 pulse
        do_reset();
        arm(32'd20, 32'd0, 32'd0, 32'd0);
        exp_reg("R10 prd readback", PLO, 32'd20);
        cyc(20);
        exp_reg("R7 cnt at period", CLO, 32'd20);
        exp_rst("R7 no rst yet", 1'b0);
        cyc(1);
        exp_rst("R7 timeout rst", 1'b1);
        cyc(15);
        exp_rst("R8 pulse last", 1'b1);
        cyc(1);
        exp_rst("R8 pulse end", 1'b0);
        cyc(20);
        exp_rst("R8 stays low", 1'b0);

        // R6 service and R9 lock
        do_reset();
        arm(32'd30, 32'd0, 32'd0, 32'd0);
        cyc(10);
        wr(PLO, 32'd3);
        wr(CLO, 32'd1000);
        wr(GCR, 32'h0);
        exp_reg("R9 prd locked", PLO, 32'd30);
        exp_reg("R9 gcr locked", GCR, 32'hB);
        wr(CTL, K0); wr(CTL, K1);
        exp_reg("R6 cnt cleared", CLO, 32'd0);
        exp_rst("R6 no rst", 1'b0);
        exp_reg("R9 enable stays", CTL, EN);
        cyc(30);
        exp_rst("R7 after service", 1'b0);
        cyc(1);
        exp_rst("R7 timeout after service", 1'b1);

        // R5 wrong key while armed, R8 not extended
        do_reset();
        arm(32'd0, 32'd1, 32'd0, 32'd0);
        cyc(3);
        exp_rst("R5 armed quiet", 1'b0);
        wr(CTL, 32'h0000_4000);
        exp_rst("R5 bad key rst", 1'b1);
        cyc(5);
        wr(CTL, 32'h0000_4000);
        cyc(8);
        exp_rst("R8 pulse last", 1'b1);
        cyc(1);
        exp_rst("R8 not extended", 1'b0);

        // R6 wrong second key
        do_reset();
        arm(32'd0, 32'd1, 32'd0, 32'd0);
        wr(CTL, K0);
        exp_rst("R6 mid service", 1'b0);
        wr(CTL, 32'h1111_4000);
        exp_rst("R6 bad second key", 1'b1);

        // R10 carry across words
        do_reset();
        arm(32'd5, 32'd1, 32'hFFFF_FFF0, 32'd0);
        cyc(16);
        exp_reg("R10 carry hi", CHI, 32'd1);
        exp_reg("R10 carry lo", CLO, 32'd0);
        cyc(5);
        exp_rst("R10 no rst", 1'b0);
        cyc(1);
        exp_rst("R10 wide timeout", 1'b1);

        cyc(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule